// File: doc/BRIEF.md
# Selectable-Length Moving-Average Filter

This block smooths a stream of signed 24-bit samples with a running mean over a window of 2, 4, 8, 16 or 32 samples. Each accepted sample is written into a circular history. A running sum adds the new sample and subtracts the one that leaves the window. An arithmetic right shift of that sum by log2 of the window length gives the mean.

The window length comes from a 5-bit mask code whose low bits are all ones. A separate control picks the output rate. In per-sample mode, one result is emitted for every accepted sample once the window is full. In decimated mode, one result is emitted per window's worth of new samples. A change of the size code flushes the history and the sum, so no result ever mixes two window lengths. Only the averaged value leaves the block; the stored history is never presented.

Top module: `runavg_filter`

## Requirements
- R1: The size code selects the window length N: 5'b00001 gives 2, 5'b00011 gives 4, 5'b00111 gives 8, 5'b01111 gives 16 and 5'b11111 gives 32.
- R2: After reset, avgValid and avgData are both zero.
- R3: avgData is the sum of the last N accepted samples, taken as 24-bit two's complement, shifted right arithmetically by log2(N). The result therefore rounds toward negative infinity.
- R4: With decimate low and the window full, every accepted sample is followed in the next cycle by a one-cycle avgValid pulse carrying the mean that includes that sample.
- R5: After reset or a size change, avgValid stays low until N samples have been accepted.
- R6: In a cycle where sizeCode differs from its value in the previous cycle, the history and the sum are cleared, the sample offered in that cycle is discarded, and no result follows.
- R7: With decimate high, a result is emitted only on the accepted samples whose count since the last clear is a multiple of N.
- R8: A code outside the five listed ones selects N = 2^k, where k is the number of consecutive ones starting at bit 0. A code with bit 0 clear selects N = 2.
- R9: A cycle with sampleValid low leaves the history and the sum unchanged, keeps avgValid low in the next cycle and holds avgData.
- R10: Changing decimate does not clear the history or restart the sample count. Decimated results stay aligned to multiples of N counted from the last clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | New sample present on sampleData this cycle |
| sampleData | input | 24 | Signed input sample |
| sizeCode | input | 5 | Window length mask code |
| decimate | input | 1 | 1: one result per window, 0: one result per sample |
| avgValid | output | 1 | One-cycle strobe marking a new mean on avgData |
| avgData | output | 24 | Signed mean; held between strobes |

## Verification
The embedded assertions check several properties on every cycle. The fill count never exceeds the window. A code change leaves the counters and the sum at zero in the following cycle. Idle cycles leave the sum and the output untouched. Every output strobe traces back to an accepted sample.

Other behaviours can only be shown by the bench's scenarios against its queue-based model. These are the actual mean values and floor rounding at the full-scale extremes, the exact cycle of the first result after a flush, decimation spacing across a decimate toggle, and the mapping of irregular codes.

// File: rtl/runavg_pkg.sv
package runavg_pkg;

  parameter int DATA_W  = 24;
  parameter int LOG_MAX = 5;

  localparam int SHIFT_W = $clog2(LOG_MAX + 1);
  localparam int DEPTH   = 1 << LOG_MAX;
  localparam int SUM_W   = DATA_W + LOG_MAX;
  localparam int CNT_W   = LOG_MAX + 1;

  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic               clear;
    logic               push;
    logic               dropOld;
    logic               emit;
    logic [LOG_MAX-1:0] wrIdx;
    logic [LOG_MAX-1:0] rdIdx;
    logic [SHIFT_W-1:0] shiftAmt;
  } avgStrobe_t;

  // log2 of the window: run of ones from bit 0, at least 1
  function automatic logic [SHIFT_W-1:0] windowLog(input logic [LOG_MAX-1:0] code);
    int  k;
    logic run;
    k   = 0;
    run = 1'b1;
    for (int i = 0; i < LOG_MAX; i++) begin
      if (run && code[i]) k = k + 1;
      else                run = 1'b0;
    end
    if (k == 0) k = 1;
    return SHIFT_W'(k);
  endfunction

endpackage

// File: rtl/runavg_ctrl.sv
module runavg_ctrl
  import runavg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic [LOG_MAX-1:0] sizeCode,
  input  logic               decimate,
  output avgStrobe_t         strobe
);

  logic [LOG_MAX-1:0] curCode;
  logic [CNT_W-1:0]   fillCnt;
  logic [CNT_W-1:0]   winLen;
  logic [LOG_MAX-1:0] phaseCnt;
  logic [LOG_MAX-1:0] wrPtr;
  logic [SHIFT_W-1:0] kNow;
  logic               codeChg;
  logic               winFull;
  logic               fillsNow;
  logic               blockEnd;
  logic               pushNow;

  always_comb begin
    kNow     = windowLog(curCode);
    winLen   = CNT_W'(1) << kNow;
    codeChg  = (sizeCode != curCode);
    winFull  = (fillCnt == winLen);
    fillsNow = winFull || (fillCnt == (winLen - CNT_W'(1)));
    blockEnd = ({1'b0, phaseCnt} == (winLen - CNT_W'(1)));
    pushNow  = sampleValid && !codeChg;

    strobe.clear    = codeChg;
    strobe.push     = pushNow;
    strobe.dropOld  = pushNow && winFull;
    strobe.emit     = pushNow && fillsNow && (!decimate || blockEnd);
    strobe.wrIdx    = wrPtr;
    strobe.rdIdx    = wrPtr - winLen[LOG_MAX-1:0];
    strobe.shiftAmt = kNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCode  <= '0;
      fillCnt  <= '0;
      phaseCnt <= '0;
      wrPtr    <= '0;
    end else if (codeChg) begin
      curCode  <= sizeCode;
      fillCnt  <= '0;
      phaseCnt <= '0;
      wrPtr    <= '0;
    end else if (sampleValid) begin
      wrPtr    <= wrPtr + 1'b1;
      if (!winFull) fillCnt <= fillCnt + 1'b1;
      phaseCnt <= blockEnd ? '0 : phaseCnt + 1'b1;
    end
  end

  AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= winLen); // R5

  AST_CHANGE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    codeChg |=> (fillCnt == '0) && (phaseCnt == '0)); // R6

endmodule

// File: rtl/runavg_datapath.sv
module runavg_datapath
  import runavg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  avgStrobe_t        strobe,
  input  logic [DATA_W-1:0] sampleData,
  output logic              avgValid,
  output logic [DATA_W-1:0] avgData
);

  logic [DATA_W-1:0]       hist [DEPTH];
  logic signed [SUM_W-1:0] sumReg;
  logic signed [SUM_W-1:0] sumNext;
  logic signed [SUM_W-1:0] addTerm;
  logic signed [SUM_W-1:0] subTerm;
  logic signed [SUM_W-1:0] meanNext;
  logic [DATA_W-1:0]       leaving;

  always_comb begin
    leaving  = hist[strobe.rdIdx];
    addTerm  = {{LOG_MAX{sampleData[DATA_W-1]}}, sampleData};
    subTerm  = strobe.dropOld ? {{LOG_MAX{leaving[DATA_W-1]}}, leaving} : '0;
    sumNext  = sumReg + addTerm - subTerm;
    meanNext = sumNext >>> strobe.shiftAmt;
  end

  // History needs no reset: a slot is subtracted only once it has been written
  always_ff @(posedge clk) begin
    if (strobe.push) hist[strobe.wrIdx] <= sampleData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumReg   <= '0;
      avgValid <= 1'b0;
      avgData  <= '0;
    end else begin
      if (strobe.clear)     sumReg <= '0;
      else if (strobe.push) sumReg <= sumNext;
      avgValid <= strobe.emit;
      if (strobe.emit) avgData <= meanNext[DATA_W-1:0];
    end
  end

  AST_SUM_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.clear) |-> (sumReg == '0)); // R6

  AST_IDLE_SUM_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.push && !strobe.clear) |=> $stable(sumReg)); // R9

endmodule

// File: rtl/runavg_filter.sv
module runavg_filter
  import runavg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic [DATA_W-1:0]  sampleData,
  input  logic [LOG_MAX-1:0] sizeCode,
  input  logic               decimate,
  output logic               avgValid,
  output logic [DATA_W-1:0]  avgData
);

  avgStrobe_t strobe;

  runavg_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .sizeCode   (sizeCode),
    .decimate   (decimate),
    .strobe     (strobe)
  );

  runavg_datapath i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sampleData(sampleData),
    .avgValid  (avgValid),
    .avgData   (avgData)
  );

  AST_VALID_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    avgValid |-> $past(sampleValid)); // R4

  AST_NO_OUT_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (sizeCode != $past(sizeCode)) |=> !avgValid); // R6

  AST_OUT_HELD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !avgValid |-> $stable(avgData)); // R9

endmodule

// File: tb/test_runavg_filter.sv
module test_runavg_filter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [23:0] sampleData = '0;
  logic [4:0]  sizeCode = 5'b00001;
  logic        decimate = 1'b0;
  logic        avgValid;
  logic [23:0] avgData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int          mHist[$];
  int          mTotal = 0;
  logic [4:0]  mPrev = 5'b00000;
  logic        expValid = 1'b0;
  logic [23:0] expData = '0;

  always #4 clk = ~clk;

  runavg_filter i_runavg_filter (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .sizeCode(sizeCode), .decimate(decimate), .avgValid(avgValid), .avgData(avgData)
  );

  function automatic int benchWindow(input logic [4:0] c);
    int n = 1;
    for (int i = 0; i < 5; i++) begin
      if (!c[i]) break;
      n = n * 2;
    end
    return (n < 2) ? 2 : n;
  endfunction

  task automatic modelEdge();
    int n;
    longint s;
    n = benchWindow(mPrev);
    expValid = 1'b0;
    if (sizeCode != mPrev) begin
      mPrev = sizeCode;
      mHist.delete();
      mTotal = 0;
    end else if (sampleValid) begin
      mHist.push_back(int'($signed(sampleData)));
      if (mHist.size() > n) void'(mHist.pop_front());
      mTotal++;
      if (mTotal >= n && (!decimate || (mTotal % n) == 0)) begin
        s = 0;
        foreach (mHist[i]) s += mHist[i];
        s = s / n - ((s % n != 0 && s < 0) ? 1 : 0);
        expData  = 24'(s);
        expValid = 1'b1;
      end
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (avgValid !== expValid) begin
      errors++;
      $display("FAIL %s avgValid actual %0b expected %0b at %0t", tag, avgValid, expValid, $time);
    end
    checks++;
    if (avgData !== expData) begin
      errors++;
      $display("FAIL %s avgData actual %h expected %h at %0t", tag, avgData, expData, $time);
    end
  endtask

  task automatic step(input logic v, input logic [23:0] d, input logic [4:0] c,
                      input logic dec, input string tag);
    sampleValid = v;
    sampleData  = d;
    sizeCode    = c;
    decimate    = dec;
    @(posedge clk);
    modelEdge();
    #2;
    compare(tag);
  endtask

  task automatic randomRun(input logic [4:0] c, input logic dec, input int count,
                           input int gapPct, input string tag);
    for (int i = 0; i < count; i++) begin
      step(($urandom % 100) >= gapPct, 24'($urandom), c, dec, tag);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R2: reset state
    checks++;
    if (avgValid !== 1'b0 || avgData !== 24'h0) begin
      errors++;
      $display("FAIL R2 reset actual %0b/%h expected 0/000000", avgValid, avgData);
    end
    @(negedge clk);
    rstN = 1'b1;
    #1;

    // R1 R4 R5: each legal code, per-sample output
    randomRun(5'b00001, 1'b0, 60, 0, "R1 R4 R5 N2");
    randomRun(5'b00011, 1'b0, 60, 0, "R1 R4 R5 N4");
    randomRun(5'b00111, 1'b0, 80, 0, "R1 R4 N8");
    randomRun(5'b01111, 1'b0, 100, 0, "R1 R4 N16");
    randomRun(5'b11111, 1'b0, 150, 0, "R1 R4 R5 N32");

    // R3: floor rounding on small negative values
    step(1'b1, 24'hFFFFFF, 5'b00001, 1'b0, "R6 flush");
    for (int i = 0; i < 6; i++) step(1'b1, (i % 2) ? 24'h0 : 24'hFFFFFF, 5'b00001, 1'b0, "R3 floor");
    step(1'b1, 24'hFFFFFD, 5'b00011, 1'b0, "R6 flush");
    for (int i = 0; i < 10; i++) step(1'b1, 24'(i) - 24'd5, 5'b00011, 1'b0, "R3 floor N4");

    // R3: full-scale extremes with the widest window
    for (int i = 0; i < 40; i++) step(1'b1, 24'h800000, 5'b11111, 1'b0, "R3 min N32");
    for (int i = 0; i < 40; i++) step(1'b1, 24'h7FFFFF, 5'b11111, 1'b0, "R3 max N32");
    for (int i = 0; i < 40; i++) step(1'b1, (i % 2) ? 24'h7FFFFF : 24'h800000, 5'b11111, 1'b0, "R3 alt N32");

    // R9: gaps in the sample stream
    randomRun(5'b00111, 1'b0, 150, 40, "R9 gaps N8");
    randomRun(5'b00011, 1'b0, 100, 70, "R9 sparse N4");

    // R7: decimated output
    randomRun(5'b00011, 1'b1, 80, 20, "R7 dec N4");
    randomRun(5'b01111, 1'b1, 120, 10, "R7 dec N16");
    randomRun(5'b11111, 1'b1, 140, 0, "R7 dec N32");

    // R10: toggling decimate mid-stream keeps alignment
    for (int i = 0; i < 120; i++)
      step(1'b1, 24'($urandom), 5'b00111, ((i / 13) % 2) == 1, "R10 toggle");

    // R6: repeated size changes with valid samples on the change cycle
    for (int r = 0; r < 6; r++) begin
      randomRun(5'b00011, 1'b0, 7, 0, "R6 change A");
      randomRun(5'b00111, 1'b1, 11, 0, "R6 change B");
    end

    // R8: irregular codes
    randomRun(5'b00000, 1'b0, 40, 10, "R8 code0");
    randomRun(5'b00101, 1'b0, 40, 10, "R8 code5");
    randomRun(5'b10111, 1'b1, 60, 0, "R8 code23");
    randomRun(5'b11110, 1'b0, 30, 0, "R8 code30");

    randomRun(5'b01111, 1'b0, 60, 30, "R4 final");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule